// File: doc/BRIEF.md
# JTAG Test Clock Generator

This block drives the JTAG test clock (TCK) for a scan engine that runs from a 64 MHz reference clock. It has two modes. In fixed mode it divides the reference by a programmable even divisor. In adaptive mode it ignores the divisor. Instead, each TCK edge waits until the target's returned clock, after a two-flop synchroniser, shows the level that was last driven.

The shift engine asks for clocking with a run request. It gets back two one-cycle strobes that mark the first cycle of each TCK high phase and each TCK low phase. TCK rests low whenever no clocking is requested.

In adaptive mode a watchdog counts the cycles spent waiting for the returned clock. When the count runs out, the block raises a one-cycle timeout pulse and issues the pending edge anyway, so the scan never hangs. The timeout is informational. Asserting test reset can produce a false timeout, so a clear input restarts the wait count and suppresses that pulse.

Top module: `jtck_gen`

## Requirements
- R1: While reset is held and in the first cycle after it, `tck_o`, `rise_o`, `fall_o` and `timeout_o` are all 0.
- R2: In fixed mode with divisor D (2 ≤ D ≤ 8190, even), TCK stays high for D/2 reference cycles and low for D/2 reference cycles. Bit 0 of `divisor_i` is ignored, so D+1 behaves exactly like D.
- R3: A divisor of 0 or 1 behaves like a divisor of 2: one cycle high and one cycle low.
- R4: The largest field values, 8190 and 8191, both give phases of 4095 cycles.
- R5: `rise_o` is 1 exactly in the first cycle in which `tck_o` is 1. `fall_o` is 1 exactly in the first cycle in which `tck_o` is 0 again. The two strobes are never 1 together.
- R6: A rising TCK edge is issued only while `run_i` is 1. If `run_i` drops during a high phase, that phase still completes with its falling edge, and TCK then stays low.
- R7: In adaptive mode (`adaptive_i`=1), TCK toggles one cycle after the synchronised return clock equals the current TCK level. With `rtck_i` wired straight to `tck_o`, each phase lasts 3 cycles.
- R8: In adaptive mode the divisor has no effect. With the loopback of R7 and divisor 8190, each phase still lasts 3 cycles.
- R9: If the return clock mismatches for TIMEOUT_CYCLES consecutive cycles, the pending edge is forced. `timeout_o` pulses for one cycle, in the same cycle as that edge's strobe, and clocking continues.
- R10: A 1 on `wait_clr_i` restarts the adaptive wait count. While it recurs more often than every TIMEOUT_CYCLES cycles, no timeout and no forced edge occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 64 MHz reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Shift engine requests TCK cycles |
| adaptive_i | input | 1 | 1 selects adaptive clocking, 0 selects fixed division |
| divisor_i | input | DIV_W (13) | Division ratio; bit 0 ignored |
| rtck_i | input | 1 | Returned clock from the target, asynchronous |
| wait_clr_i | input | 1 | Restarts the adaptive wait count (clears a false timeout) |
| tck_o | output | 1 | Test clock |
| rise_o | output | 1 | One-cycle strobe in the first high cycle of TCK |
| fall_o | output | 1 | One-cycle strobe in the first low cycle of TCK |
| timeout_o | output | 1 | One-cycle pulse when an adaptive wait expires |

## Verification
A corrupted divide counter shows up as a TCK phase of the wrong length, and it does so within the first phase after the fault. An edge flop that drifts from the strobe flops shows up as a strobe that does not line up with the TCK transition, in the very cycle of the edge. A wrong adaptive wait count shows up either as a timeout pulse that arrives early or late against the TIMEOUT_CYCLES window, or as a high phase that never ends. A clear that does not reach the counter shows up as a forced edge within one timeout window.

// File: rtl/jtck_pkg.sv
package jtck_pkg;
  typedef enum logic {
    CLK_FIXED = 1'b0,
    CLK_ADAPT = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/jtck_sync.sv
module jtck_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/jtck_fixed_timer.sv
module jtck_fixed_timer #(
  parameter int DIV_W = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] divisor_i,
  output logic             fire_o
);
  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  // phase length in reference cycles; bit 0 of the divisor drops out, floor of one
  always_comb begin
    half = divisor_i >> 1;
    if (half == '0) half = DIV_W'(1);
  end

  always_comb begin
    fire_o = en_i && (cnt_q >= half - DIV_W'(1));
    if (!en_i || fire_o) cnt_d = '0;
    else                 cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_PHASE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && en_i && $stable(divisor_i)) |-> (cnt_q < half)); // R2
endmodule

// File: rtl/jtck_adapt_watch.sv
module jtck_adapt_watch #(
  parameter int TO_CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic level_i,
  input  logic rtck_s_i,
  input  logic clr_i,
  output logic fire_o,
  output logic expire_o
);
  localparam int CNT_W = (TO_CYCLES > 2) ? $clog2(TO_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CYCLES - 1);

  logic             match;
  logic [CNT_W-1:0] wcnt_q;
  logic [CNT_W-1:0] wcnt_d;

  always_comb begin
    match    = (rtck_s_i == level_i);
    expire_o = en_i && !match && !clr_i && (wcnt_q == LAST);
    fire_o   = en_i && (match || expire_o);
    if (!en_i || fire_o || clr_i) wcnt_d = '0;
    else                          wcnt_d = wcnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wcnt_q <= '0;
    else         wcnt_q <= wcnt_d;
  end

  AST_WAIT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(clr_i) |-> (wcnt_q == '0)); // R10
endmodule

// File: rtl/jtck_gen.sv
module jtck_gen #(
  parameter int DIV_W       = 13,
  parameter int TO_CYCLES   = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             adaptive_i,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             rtck_i,
  input  logic             wait_clr_i,
  output logic             tck_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             timeout_o
);
  import jtck_pkg::*;

  clk_mode_e mode;
  logic      rtck_s;
  logic      active;
  logic      fix_fire;
  logic      ad_fire;
  logic      ad_expire;
  logic      edge_en;
  logic      tck_q, tck_d;
  logic      rise_q, rise_d;
  logic      fall_q, fall_d;
  logic      to_q, to_d;

  assign mode   = clk_mode_e'(adaptive_i);
  // a high phase must always finish; a new one needs a request
  assign active = tck_q || run_i;

  jtck_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rtck_i),
    .q_o    (rtck_s)
  );

  jtck_fixed_timer #(.DIV_W(DIV_W)) u_fixed (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (active && (mode == CLK_FIXED)),
    .divisor_i (divisor_i),
    .fire_o    (fix_fire)
  );

  jtck_adapt_watch #(.TO_CYCLES(TO_CYCLES)) u_watch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (active && (mode == CLK_ADAPT)),
    .level_i  (tck_q),
    .rtck_s_i (rtck_s),
    .clr_i    (wait_clr_i),
    .fire_o   (ad_fire),
    .expire_o (ad_expire)
  );

  always_comb begin
    edge_en = active && ((mode == CLK_ADAPT) ? ad_fire : fix_fire);
    tck_d   = tck_q ^ edge_en;
    rise_d  = edge_en && !tck_q;
    fall_d  = edge_en && tck_q;
    to_d    = ad_expire;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tck_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      tck_q  <= tck_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
      to_q   <= to_d;
    end
  end

  assign tck_o     = tck_q;
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;
  assign timeout_o = to_q;

  AST_RISE_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tck_o && !run_i) |=> !tck_o); // R6
  AST_RISE_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (tck_o && !$past(tck_o))); // R5
  AST_FALL_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!tck_o && $past(tck_o))); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o)); // R5
  AST_TIMEOUT_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> ((rise_o || fall_o) && $past(adaptive_i))); // R9
endmodule

// File: tb/tb_jtck_gen.sv
module tb_jtck_gen;
  localparam int DIV_W = 13;
  localparam int TO    = 40;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             run, adaptive, clr, loop_en, rtck_force;
  logic [DIV_W-1:0] divisor;
  logic             rtck;
  logic             tck, rise, fall, tmo;
  int               n_chk = 0;
  int               n_fail = 0;
  bit               done = 0;

  always #4 clk = ~clk;
  assign rtck = loop_en ? tck : rtck_force;

  jtck_gen #(.DIV_W(DIV_W), .TO_CYCLES(TO), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .adaptive_i(adaptive),
    .divisor_i(divisor), .rtck_i(rtck), .wait_clr_i(clr),
    .tck_o(tck), .rise_o(rise), .fall_o(fall), .timeout_o(tmo));

  localparam int NV = 8;
  localparam logic [DIV_W-1:0] V_DIV [NV] = '{13'd2, 13'd3, 13'd0, 13'd1,
                                              13'd10, 13'd11, 13'd8190, 13'd8191};
  localparam int V_HALF [NV] = '{1, 1, 1, 1, 5, 5, 4095, 4095};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(output int hi, output int lo, output int rs, output int fs);
    int guard = 0;
    hi = 0; lo = 0;
    while (tck !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    rs = int'(rise);
    while (tck === 1'b1 && guard < 20000) begin hi++; @(negedge clk); guard++; end
    fs = int'(fall);
    while (tck === 1'b0 && guard < 20000) begin lo++; @(negedge clk); guard++; end
  endtask

  task automatic idle(input int n);
    run = 0; adaptive = 0; loop_en = 0; rtck_force = 0; clr = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    int hi, lo, rs, fs, cnt;
    rst_n = 0; run = 0; adaptive = 0; clr = 0; loop_en = 0; rtck_force = 0;
    divisor = 13'd2;
    repeat (3) @(negedge clk);
    check("R1 tck in reset", int'(tck), 0);
    check("R1 strobes in reset", int'(rise | fall | tmo), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 outputs after reset", int'(tck | rise | fall | tmo), 0);

    // R6: no request, no clock
    cnt = 0;
    repeat (50) begin @(negedge clk); cnt += int'(tck | rise); end
    check("R6 idle stays low", cnt, 0);

    // R2 R3 R4 R5: table of divisors
    for (int i = 0; i < NV; i++) begin
      divisor = V_DIV[i];
      run = 1;
      measure(hi, lo, rs, fs);
      check($sformatf("R2/R3/R4 high div=%0d", V_DIV[i]), hi, V_HALF[i]);
      check($sformatf("R2/R3/R4 low div=%0d", V_DIV[i]), lo, V_HALF[i]);
      check("R5 rise strobe on first high", rs, 1);
      check("R5 fall strobe on first low", fs, 1);
      idle(V_HALF[i] + 5);
    end

    // R6: request dropped mid high phase
    divisor = 13'd20; run = 1;
    while (tck !== 1'b1) @(negedge clk);
    run = 0;
    hi = 0;
    while (tck === 1'b1 && hi < 100) begin hi++; @(negedge clk); end
    check("R6 started phase completes", hi, 10);
    cnt = 0;
    repeat (100) begin @(negedge clk); cnt += int'(tck | rise); end
    check("R6 stays low after drop", cnt, 0);

    // R7: adaptive with loopback
    adaptive = 1; loop_en = 1; divisor = 13'd2; run = 1;
    measure(hi, lo, rs, fs);
    check("R7 adaptive loopback high", hi, 3);
    check("R7 adaptive loopback low", lo, 3);
    check("R7 no timeout in loopback", int'(tmo), 0);
    idle(20);

    // R8: divisor ignored in adaptive mode
    adaptive = 1; loop_en = 1; divisor = 13'd8190; run = 1;
    measure(hi, lo, rs, fs);
    check("R8 divisor ignored high", hi, 3);
    check("R8 divisor ignored low", lo, 3);
    idle(20);

    // R9: no answer from target
    adaptive = 1; loop_en = 0; rtck_force = 0; run = 1;
    measure(hi, lo, rs, fs);
    check("R9 forced fall after window", hi, TO);
    check("R9 timeout with forced edge", fs, 1);
    check("R9 clock continues", lo, 1);
    run = 0;
    repeat (TO + 10) @(negedge clk);

    // R10: clear holds off the timeout
    run = 1;
    while (tck !== 1'b1) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      clr = (k % 30 == 0);
      @(negedge clk);
      cnt += int'(tmo | fall);
    end
    clr = 0;
    check("R10 no timeout while clearing", cnt, 0);
    check("R10 tck held high", int'(tck), 1);
    run = 0;
    cnt = 0;
    repeat (TO + 5) begin @(negedge clk); cnt += int'(tmo); end
    check("R9 single pulse after clear stops", cnt, 1);
    idle(10);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule